// File: doc/BRIEF.md
# Microcode Sequencer Issue Takeover

This block is the issue front end of a small machine that runs decoded operations. Decoders write entries into a queue of 56 slots at its tail. A short instruction is written as plain micro-ops, one slot each. A long instruction takes a single indirect slot that holds a start address into an internal microcode ROM. Plain entries at the head of the queue go straight to a single-wide issue port that uses a valid/ready handshake.

When an indirect entry reaches the head, the sequencer removes it from the queue and takes over the issue port. It plays the ROM routine one micro-op per accepted cycle. A routine may branch inside the ROM on a repeat count, and it may loop a body that many times. The repeat count is sampled from a register-value input at the moment of takeover. After the routine's final micro-op, the issue port goes back to the queue. During the whole takeover the decoders can keep writing the queue until it is full.

Two event counters are kept. One counts hand-overs from queue issue to sequencer issue. The other counts queue writes accepted while the sequencer is active.

Top module: `mseq_issue`

## Requirements
- R1: A plain entry (`wr_ind`=0) is issued unchanged on `iss_uop` with `iss_seq`=0. Plain entries issue in write order, at most one per cycle, each when `iss_ready` is high.
- R2: When an indirect entry (`wr_ind`=1, ROM address in `wr_data[4:0]`) reaches the head, it is consumed with exactly one cycle that issues nothing. From the next cycle, ROM micro-ops are issued with `iss_seq`=1, and each payload equals 0x80 OR its ROM address.
- R3: Entries written after an indirect entry issue only after every micro-op of its routine. The first of them issues in the cycle right after the routine's final micro-op is accepted.
- R4: The repeat count is taken from `rep_cnt` in the takeover cycle. A routine loops its body that many times.
- R5: The ROM routine at address 0 issues 0x80, then 0x81 N times, then 0x82. The routine at address 4 issues 0x84 to 0x88. The routine at address 12 issues 0x8C, then the pair 0x8D, 0x8E N times, then 0x8F.
- R6: With a repeat count of zero, the loop body is skipped by a ROM jump. Routine 0 issues 0x80, 0x82. Routine 12 issues 0x8C and then its alternate exit 0x90.
- R7: While `iss_valid` is high and `iss_ready` is low, `iss_uop` holds its value and no micro-op is lost or repeated.
- R8: The queue accepts writes while the sequencer owns the issue port, up to 56 entries. `wr_ready` is low when the queue is full, and a write offered while it is low is dropped.
- R9: `cnt_switch` increases by one for each takeover by the sequencer.
- R10: `cnt_ms_wr` increases by one for each accepted write in a cycle where `iss_seq` is high.
- R11: Reset empties the queue, returns the sequencer to idle and clears both counters. The reset is asserted asynchronously and released after two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Decoder offers a queue entry |
| wr_ready | output | 1 | Queue has a free slot |
| wr_ind | input | 1 | Entry is indirect (ROM pointer) |
| wr_data | input | 8 | Micro-op, or ROM start address in bits 4:0 |
| rep_cnt | input | 8 | Repeat count register value |
| iss_valid | output | 1 | Issue port holds a micro-op |
| iss_ready | input | 1 | Downstream accepts the micro-op |
| iss_uop | output | 8 | Issued micro-op |
| iss_seq | output | 1 | Micro-op comes from the sequencer |
| cnt_switch | output | 16 | Takeover event count |
| cnt_ms_wr | output | 16 | Writes accepted while sequencer busy |

## Verification
The bench checks the exact cycle of each hand-over. A design that skipped the idle takeover cycle, or that resumed queue issue one cycle late, would shift the issue times that the bench records. Zero-count routines are run for both jump shapes: a wrong branch condition would issue a body micro-op or the wrong exit. The bench fills the queue completely behind a stalled routine and offers extra writes. A queue that stopped accepting during takeover, or that overwrote entries when full, would change the counter value or the drained order. A mid-run reset is applied with entries still pending, so that stale entries or a leftover sequencer state would be detected.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UOP_W = 8;
  localparam int ROM_AW = 5;
  localparam int RPT_W = 8;

  typedef struct packed {
    logic [UOP_W-1:0]  pay;
    logic              eor;
    logic              jmp;
    logic              lp;
    logic [ROM_AW-1:0] tgt;
  } rom_word_t;

  // Computed ROM: payload marks sequencer origin in the top bit.
  function automatic rom_word_t rom_word(input logic [ROM_AW-1:0] a);
    rom_word_t w;
    w.pay = {1'b1, {(UOP_W-1-ROM_AW){1'b0}}, a};
    w.eor = 1'b0;
    w.jmp = 1'b0;
    w.lp  = 1'b0;
    w.tgt = '0;
    case (a)
      ROM_AW'(0):  begin w.jmp = 1'b1; w.tgt = ROM_AW'(2); end
      ROM_AW'(1):  begin w.lp = 1'b1; w.jmp = 1'b1; w.tgt = ROM_AW'(1); end
      ROM_AW'(2):  w.eor = 1'b1;
      ROM_AW'(4), ROM_AW'(5), ROM_AW'(6), ROM_AW'(7): w.eor = 1'b0;
      ROM_AW'(8):  w.eor = 1'b1;
      ROM_AW'(12): begin w.jmp = 1'b1; w.tgt = ROM_AW'(16); end
      ROM_AW'(13): w.eor = 1'b0;
      ROM_AW'(14): begin w.lp = 1'b1; w.jmp = 1'b1; w.tgt = ROM_AW'(13); end
      ROM_AW'(15): w.eor = 1'b1;
      default:     w.eor = 1'b1;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/mseq_queue.sv
module mseq_queue #(
  parameter int DEPTH = 56,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] n_q, n_d;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d = push ? wrap_inc(wp_q) : wp_q;
    rp_d = pop  ? wrap_inc(rp_q) : rp_q;
    n_d  = n_q + CNTW'(push) - CNTW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      n_q  <= n_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign valid = (n_q != '0);
  assign full  = (n_q == CNTW'(DEPTH));
endmodule

// File: rtl/mseq_seq.sv
module mseq_seq
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROM_AW-1:0] addr_i,
  input  logic [RPT_W-1:0]  cnt_i,
  input  logic              adv_i,
  output logic              busy_o,
  output logic [UOP_W-1:0]  uop_o
);
  logic              busy_q, busy_d;
  logic [ROM_AW-1:0] addr_q, addr_d;
  logic [RPT_W-1:0]  cnt_q, cnt_d;
  rom_word_t         w;

  always_comb begin
    w      = rom_word(addr_q);
    busy_d = busy_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        addr_d = addr_i;
        cnt_d  = cnt_i;
      end
    end else if (adv_i) begin
      if (w.eor) begin
        busy_d = 1'b0;
      end else if (w.lp) begin
        cnt_d  = cnt_q - 1'b1;
        addr_d = (w.jmp && cnt_q != RPT_W'(1)) ? w.tgt : addr_q + 1'b1;
      end else if (w.jmp && cnt_q == '0) begin
        addr_d = w.tgt;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign uop_o  = w.pay;
endmodule

// File: rtl/mseq_issue.sv
module mseq_issue
  import mseq_pkg::*;
#(
  parameter int QDEPTH = 56,
  parameter int CW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_ind,
  input  logic [UOP_W-1:0] wr_data,
  input  logic [RPT_W-1:0] rep_cnt,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [UOP_W-1:0] iss_uop,
  output logic             iss_seq,
  output logic [CW-1:0]    cnt_switch,
  output logic [CW-1:0]    cnt_ms_wr
);
  localparam int EW = UOP_W + 1;

  logic [1:0]       rs_q;
  logic             rst_ni;
  logic             q_full, q_valid, push, pop, head_ok, start, adv, busy;
  logic [EW-1:0]    head;
  logic [UOP_W-1:0] seq_uop;
  logic [CW-1:0]    sw_d, mw_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  mseq_queue #(.DEPTH(QDEPTH), .W(EW)) u_q (
    .clk(clk), .rst_n(rst_ni), .push(push), .din({wr_ind, wr_data}),
    .pop(pop), .dout(head), .valid(q_valid), .full(q_full)
  );

  mseq_seq u_seq (
    .clk(clk), .rst_n(rst_ni), .start_i(start), .addr_i(head[ROM_AW-1:0]),
    .cnt_i(rep_cnt), .adv_i(adv), .busy_o(busy), .uop_o(seq_uop)
  );

  always_comb begin
    wr_ready  = !q_full;
    push      = wr_valid && !q_full;
    head_ok   = q_valid && !busy;
    start     = head_ok && head[EW-1];
    pop       = head_ok && (head[EW-1] || iss_ready);
    adv       = busy && iss_ready;
    iss_valid = busy || (head_ok && !head[EW-1]);
    iss_uop   = busy ? seq_uop : head[UOP_W-1:0];
    iss_seq   = busy;
    sw_d      = cnt_switch + 1'b1;
    mw_d      = cnt_ms_wr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_switch <= '0;
      cnt_ms_wr  <= '0;
    end else begin
      if (start)        cnt_switch <= sw_d;
      if (push && busy) cnt_ms_wr  <= mw_d;
    end
  end
endmodule

// File: rtl/mseq_issue_chk.sv
module mseq_issue_chk #(
  parameter int UW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic [UW-1:0] iss_uop,
  input logic          iss_seq,
  input logic [CW-1:0] cnt_switch,
  input logic [CW-1:0] cnt_ms_wr
);
  p_rom_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_seq |-> (iss_valid && iss_uop[UW-1]));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_uop)));

  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(cnt_ms_wr));

  p_switch_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iss_seq) |-> (cnt_switch != $past(cnt_switch)));

  p_ms_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ms_wr != $past(cnt_ms_wr)) |-> $past(iss_seq));
endmodule

bind mseq_issue mseq_issue_chk #(.UW(mseq_pkg::UOP_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_uop(iss_uop),
  .iss_seq(iss_seq), .cnt_switch(cnt_switch), .cnt_ms_wr(cnt_ms_wr)
);

// File: tb/mseq_issue_test.sv
module mseq_issue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_ind = 1'b0, iss_ready = 1'b0;
  logic [7:0]  wr_data = '0, rep_cnt = '0;
  logic        wr_ready, iss_valid, iss_seq;
  logic [7:0]  iss_uop;
  logic [15:0] cnt_switch, cnt_ms_wr;

  int total = 0, bad = 0, cyc = 0, nget = 0, exp_n = 0;
  bit done = 1'b0;
  logic [7:0] got_u [256];
  bit         got_s [256];
  int         got_t [256];
  logic [7:0] exp_u [256];
  bit         exp_s [256];

  // row: {indirect, data, repeat, uops of the row itself}
  localparam logic [24:0] TBL [6] = '{
    {1'b0, 8'h33, 8'd0, 8'd1},
    {1'b1, 8'h00, 8'd3, 8'd5},
    {1'b1, 8'h00, 8'd0, 8'd2},
    {1'b1, 8'h04, 8'd7, 8'd5},
    {1'b1, 8'h0C, 8'd2, 8'd6},
    {1'b1, 8'h0C, 8'd0, 8'd2}
  };

  mseq_issue uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ind(wr_ind), .wr_data(wr_data), .rep_cnt(rep_cnt),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_uop(iss_uop),
    .iss_seq(iss_seq), .cnt_switch(cnt_switch), .cnt_ms_wr(cnt_ms_wr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (iss_valid && iss_ready && nget < 256) begin
      got_u[nget] = iss_uop;
      got_s[nget] = iss_seq;
      got_t[nget] = cyc;
      nget = nget + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic add(input logic [7:0] u, input bit s);
    exp_u[exp_n] = u;
    exp_s[exp_n] = s;
    exp_n++;
  endtask

  task automatic model(input bit ind, input logic [7:0] d, input int n);
    exp_n = 0;
    add(8'h11, 1'b0);
    if (!ind) add(d, 1'b0);
    else if (d == 8'h00) begin
      add(8'h80, 1'b1); repeat (n) add(8'h81, 1'b1); add(8'h82, 1'b1);
    end else if (d == 8'h04) begin
      for (int k = 4; k <= 8; k++) add(8'h80 | 8'(k), 1'b1);
    end else if (n == 0) begin
      add(8'h8C, 1'b1); add(8'h90, 1'b1);
    end else begin
      add(8'h8C, 1'b1);
      repeat (n) begin add(8'h8D, 1'b1); add(8'h8E, 1'b1); end
      add(8'h8F, 1'b1);
    end
    add(8'h22, 1'b0);
  endtask

  task automatic push(input bit ind, input logic [7:0] d);
    wr_valid = 1'b1; wr_ind = ind; wr_data = d;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R11: reset state
    chk(iss_valid == 1'b0, "R11", "iss_valid after reset", iss_valid, 0);
    chk(wr_ready == 1'b1, "R11", "wr_ready after reset", wr_ready, 1);
    chk(cnt_switch == 0 && cnt_ms_wr == 0, "R11", "counters after reset",
        cnt_switch + cnt_ms_wr, 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    @(posedge clk); #1;
    iss_ready = 1'b1;
    for (int r = 0; r < 6; r++) begin
      rep_cnt = TBL[r][15:8];
      model(TBL[r][24], TBL[r][23:16], int'(TBL[r][15:8]));
      nget = 0;
      push(1'b0, 8'h11);
      push(TBL[r][24], TBL[r][23:16]);
      push(1'b0, 8'h22);
      repeat (30) @(posedge clk);
      #1;
      chk(nget == int'(TBL[r][7:0]) + 2, "R5", $sformatf("row %0d uop count", r),
          nget, int'(TBL[r][7:0]) + 2);
      for (int k = 0; k < exp_n && k < nget; k++) begin
        chk(got_u[k] == exp_u[k] && got_s[k] == exp_s[k],
            TBL[r][24] ? (TBL[r][15:8] == 0 ? "R6" : "R4") : "R1",
            $sformatf("row %0d uop %0d", r, k), {got_s[k], got_u[k]},
            {exp_s[k], exp_u[k]});
      end
      if (nget == exp_n) begin
        if (TBL[r][24]) begin
          chk(got_t[1] - got_t[0] == 2, "R2", "one idle takeover cycle",
              got_t[1] - got_t[0], 2);
          chk(got_t[nget-1] - got_t[nget-2] == 1, "R3", "resume next cycle",
              got_t[nget-1] - got_t[nget-2], 1);
        end else begin
          chk(got_t[2] - got_t[0] == 2, "R1", "one plain uop per cycle",
              got_t[2] - got_t[0], 2);
        end
      end
    end
    chk(cnt_switch == 16'd5, "R9", "takeover count", cnt_switch, 5);

    // Fill behind a stalled routine: R7 R8 R10
    do_reset();
    iss_ready = 1'b0;
    rep_cnt = 8'd5;
    push(1'b1, 8'h00);
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < 56; i++) push(1'b0, 8'(i));
    @(negedge clk);
    chk(wr_ready == 1'b0, "R8", "wr_ready when full", wr_ready, 0);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_ind = 1'b0; wr_data = 8'h7F;
    repeat (3) @(posedge clk);
    #1 wr_valid = 1'b0;
    @(negedge clk);
    chk(cnt_ms_wr == 16'd56, "R10", "writes while busy", cnt_ms_wr, 56);
    chk(cnt_switch == 16'd1, "R9", "single takeover", cnt_switch, 1);
    chk(iss_valid && iss_seq && iss_uop == 8'h80, "R7", "held first rom uop",
        iss_uop, 8'h80);
    nget = 0;
    @(posedge clk); #1;
    iss_ready = 1'b1;
    repeat (90) @(posedge clk);
    #1;
    chk(nget == 63, "R8", "drained count", nget, 63);
    if (nget == 63) begin
      chk(got_u[0] == 8'h80 && got_u[6] == 8'h82, "R7", "routine after stall",
          {got_u[0], got_u[6]}, 16'h8082);
      for (int i = 0; i < 56; i++)
        chk(got_u[7+i] == 8'(i) && !got_s[7+i], "R8", $sformatf("queued %0d", i),
            got_u[7+i], i);
    end

    // Mid-run reset with pending entries: R11
    iss_ready = 1'b0;
    push(1'b0, 8'h44);
    push(1'b1, 8'h04);
    do_reset();
    @(negedge clk);
    chk(!iss_valid && !iss_seq, "R11", "idle after mid reset", iss_valid, 0);
    chk(cnt_switch == 0 && cnt_ms_wr == 0, "R11", "counters after mid reset",
        cnt_switch + cnt_ms_wr, 0);
    nget = 0;
    @(posedge clk); #1;
    iss_ready = 1'b1;
    push(1'b0, 8'h55);
    repeat (4) @(posedge clk); #1;
    chk(nget == 1 && got_u[0] == 8'h55, "R11", "queue emptied by reset",
        got_u[0], 8'h55);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule